// File: doc/BRIEF.md
# Serial DAC Write-and-Update Frame Engine

This block drives one write-and-update command into a four-channel, 12-bit serial DAC and collects the 32 bits the DAC returns while that command is shifted in. A single-cycle `start` pulse latches a channel code and a level. The block then runs one 32-bit frame on an SPI link with the clock idling low. Each bit is placed on `sdo` while `sck` is low. The DAC's reply on `sdi` is taken on the final system clock of each high phase, which is the last instant before `sck` falls. This is needed because the DAC's output settles slowly.

The transmitted word is padded to 32 bits so that the DAC's reply lines up with a whole command. The word carries a zero byte, then the write-and-update nibble beside the channel code, then the level left-justified over four zero bits. Because the DAC shifts its previous contents out as the new word goes in, the captured readback is the command sent in the preceding frame. A separate `clr_req` pulse makes a fixed-length active-low pulse on the DAC clear line. The bus timing comes from the `HALF` parameter, which sets the number of system clocks in each SCK half-period. The clear width comes from `CLR_LEN`.

Top module: `spi_dac_writer`

## Requirements
- R1: After reset, `sck` is 0, `cs_n` is 1, `clr_n` is 1, `busy` and `done` are 0, and `readback` is zero.
- R2: A frame shifts out 32 bits, most significant first: bits 31..24 are 0x00, bits 23..20 are 0b0011, bits 19..16 are the channel code, bits 15..4 are the level, and bits 3..0 are zero.
- R3: The channel code is taken as 4 bits and placed unaltered in its field. Codes 0 to 3 address channels A to D, and 0xF addresses all four.
- R4: `sck` stays low whenever `cs_n` is high. Each bit has a low phase followed by a high phase, each lasting `HALF` system clocks. There are exactly 32 rising edges per frame.
- R5: `sdi` is sampled on the final system clock of each high phase, so a reply bit that only becomes valid on that clock is still captured correctly.
- R6: `cs_n` falls on the edge that accepts `start`, before the first bit. It rises after the 32nd falling edge plus one further low phase. `done` appears 65·HALF clocks after the accepting edge.
- R7: When a frame ends, `readback` takes the 32 bits received, first bit received in bit 31. When the DAC echoes its previous word, this equals the command of the preceding frame, or zero after reset. `readback` changes at no other time.
- R8: `done` is a one-cycle pulse in the first cycle that `cs_n` is high again. `busy` is high from the accepting edge until that same cycle.
- R9: A `start` pulse while `busy` is high is ignored and starts no frame.
- R10: In idle, `clr_req` drives `clr_n` low for exactly `CLR_LEN` clocks. During that time `cs_n` stays high, `sck` and `sdo` stay low, and `busy` is high, so `start` is ignored. If `start` and `clr_req` arrive in the same idle cycle, `start` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send a frame |
| chan | input | 4 | Channel code (0-3 single channel, 0xF all) |
| level | input | 12 | Output level for the addressed channel |
| clr_req | input | 1 | One-cycle request for a clear pulse |
| sdi | input | 1 | Serial data returned by the DAC |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the DAC |
| cs_n | output | 1 | Active-low chip select; rising edge commits |
| clr_n | output | 1 | Active-low DAC clear |
| busy | output | 1 | Frame or clear pulse in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| readback | output | 32 | Word received during the last frame |

## Verification
Counting from the clock edge that accepts `start`, `done` and the new `readback` are due exactly 65·HALF edges later. A clear request holds `clr_n` low for `CLR_LEN` cycles, starting from the edge that accepts it. The bench drives stimulus on falling clock edges and counts edges until each result. It then compares that count with these figures, sampling only at falling edges. Its DAC model presents each reply bit inverted until the final clock of each high phase, so any earlier sampling corrupts the readback.

// File: rtl/spi_dac_writer.sv
module spi_dac_writer #(
  parameter int HALF    = 4,
  parameter int CLR_LEN = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  chan,
  input  logic [11:0] level,
  input  logic        clr_req,
  input  logic        sdi,
  output logic        sck,
  output logic        sdo,
  output logic        cs_n,
  output logic        clr_n,
  output logic        busy,
  output logic        done,
  output logic [31:0] readback
);
  localparam int CW  = $clog2(HALF + 1);
  localparam int KW  = $clog2(CLR_LEN + 1);
  localparam logic [3:0] WR_UPD = 4'b0011;

  typedef enum logic [2:0] {IDLE, LO, HI, TAIL, CLR} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [KW-1:0] ccnt;
  logic [4:0]  bitn;
  logic [31:0] tx, rx;

  wire phase_end = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      ccnt     <= '0;
      bitn     <= '0;
      tx       <= '0;
      rx       <= '0;
      readback <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          if (start) begin
            tx   <= {8'h00, WR_UPD, chan, level, 4'h0};
            cnt  <= '0;
            bitn <= 5'd31;
            st   <= LO;
          end else if (clr_req) begin
            ccnt <= '0;
            st   <= CLR;
          end
        end
        LO: begin
          if (phase_end) begin
            cnt <= '0;
            st  <= HI;
          end else cnt <= cnt + 1'b1;
        end
        HI: begin
          if (phase_end) begin
            cnt <= '0;
            rx  <= {rx[30:0], sdi};
            tx  <= {tx[30:0], 1'b0};
            if (bitn == 5'd0) st <= TAIL;
            else begin
              bitn <= bitn - 1'b1;
              st   <= LO;
            end
          end else cnt <= cnt + 1'b1;
        end
        TAIL: begin
          if (phase_end) begin
            cnt      <= '0;
            readback <= rx;
            done     <= 1'b1;
            st       <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        CLR: begin
          if (ccnt == KW'(CLR_LEN - 1)) st <= IDLE;
          else ccnt <= ccnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign sck   = (st == HI);
  assign cs_n  = !(st == LO || st == HI || st == TAIL);
  assign sdo   = cs_n ? 1'b0 : tx[31];
  assign clr_n = (st != CLR);
  assign busy  = (st != IDLE);

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R10
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (cs_n && !sck && !sdo && busy));

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy && $past(!cs_n)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(readback));

  // R6
  cs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (done && !$past(sck)));
endmodule

// File: tb/spi_dac_writer_test.sv
module spi_dac_writer_test;
  localparam int HALF    = 4;
  localparam int CLR_LEN = 5;

  logic clk = 0, rst_n = 0, start = 0, clr_req = 0;
  logic [3:0] chan = 0;
  logic [11:0] level = 0;
  logic sdi, sck, sdo, cs_n, clr_n, busy, done;
  logic [31:0] readback;

  int pass_n = 0, fail_n = 0;
  logic [31:0] dsr = 0, last_frame = 0, prev_cmd = 0;
  logic in_bit = 0, ok_r = 1;
  int nrise = 0;

  always #10 clk = ~clk;

  spi_dac_writer #(.HALF(HALF), .CLR_LEN(CLR_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .level(level),
    .clr_req(clr_req), .sdi(sdi), .sck(sck), .sdo(sdo), .cs_n(cs_n),
    .clr_n(clr_n), .busy(busy), .done(done), .readback(readback));

  // DAC model: reply bit valid only on the last clock of each high phase
  always @(posedge sck) begin
    in_bit = sdo;
    nrise++;
    ok_r = 0;
    repeat (HALF - 1) @(posedge clk);
    ok_r = 1;
  end
  always @(negedge sck) if (!cs_n) dsr = {dsr[30:0], in_bit};
  always @(posedge cs_n) last_frame = dsr;
  assign sdi = ok_r ? dsr[31] : ~dsr[31];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic frame(input logic [3:0] ch, input logic [11:0] lv, input bit poke);
    logic [31:0] exp;
    int n, r0;
    exp = {8'h00, 4'b0011, ch, lv, 4'h0};
    r0 = nrise;
    @(negedge clk);
    chan = ch; level = lv; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    n = 1;
    chk(!cs_n && !sck && busy, "R6", "cs low before first bit", {30'd0, cs_n, sck}, 32'd0);
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 100) begin chan = ~ch; level = ~lv; start = 1; end
      if (poke && n == 101) start = 0;
    end
    chk(n == 65 * HALF + 1, "R6", "frame length", n, 65 * HALF + 1);
    chk(cs_n && !busy, "R8", "done with cs high", {30'd0, cs_n, busy}, 32'd2);
    chk(nrise - r0 == 32, "R4", "sck rising edges", nrise - r0, 32);
    chk(last_frame == exp, "R2 R3", "frame sent", last_frame, exp);
    chk(readback == prev_cmd, "R5 R7", "readback echo", readback, prev_cmd);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(!busy && cs_n && nrise - r0 == 32, "R9", "no restart from busy start",
        {31'd0, busy}, 32'd0);
    prev_cmd = exp;
  endtask

  initial begin
    #(200000 * 20);
    fail_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sck && cs_n && clr_n && !busy && !done && readback == 0, "R1", "reset state",
        {readback[27:0], sck, cs_n, clr_n, busy}, 32'h6);
    rst_n = 1;
    @(negedge clk);
    chk(!sck && cs_n && readback == 0, "R1", "after reset release", readback, 0);

    frame(4'h0, 12'h000, 1'b0);
    frame(4'hF, 12'hFFF, 1'b0);
    for (int c = 0; c < 16; c++)
      frame(4'(c), 12'((c * 273) ^ 12'h5A3), c == 5);

    begin : clear_test
      int low_n, r0;
      logic [31:0] rb;
      bit quiet;
      rb = readback; r0 = nrise; low_n = 0; quiet = 1;
      @(negedge clk);
      clr_req = 1;
      @(negedge clk);
      clr_req = 0; start = 1;
      while (!clr_n && low_n < 100) begin
        low_n++;
        if (!cs_n || sck || sdo) quiet = 0;
        @(negedge clk);
        start = 0;
      end
      chk(low_n == CLR_LEN, "R10", "clear width", low_n, CLR_LEN);
      chk(quiet, "R10", "bus quiet in clear", {31'd0, quiet}, 1);
      @(negedge clk);
      chk(!busy && cs_n && nrise == r0 && readback == rb, "R10", "start ignored in clear",
          {31'd0, busy}, 0);
    end

    begin : prio_test
      @(negedge clk);
      clr_req = 1; start = 1; chan = 4'h2; level = 12'h800;
      @(negedge clk);
      clr_req = 0; start = 0;
      chk(!cs_n && clr_n, "R10", "start wins over clear", {30'd0, cs_n, clr_n}, 1);
      while (!done) @(negedge clk);
      chk(readback == prev_cmd, "R7", "echo after priority frame", readback, prev_cmd);
      prev_cmd = {8'h00, 4'b0011, 4'h2, 12'h800, 4'h0};
      chk(last_frame == prev_cmd, "R2", "priority frame content", last_frame, prev_cmd);
    end

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule